// File: doc/BRIEF.md
# Dual External Interrupt Flag Unit

This block turns two asynchronous request pins into two interrupt request flags for a processor core. Each pin is first brought into the clock domain by a short flip-flop chain. It is then adjusted for its configured active level, high or low, and judged either by edge or by level. The trigger type and the two flags are held in a 4-bit control nibble that software writes and reads back. The active-level selects come from a separate configuration input.

In edge mode a flag latches on an inactive-to-active transition. It stays set until software writes it to zero or the core pulses the acknowledge strobe for that input. In level mode the flag tracks the adjusted pin every cycle, so acknowledges and writes leave no lasting mark. The adjusted, synchronized level of each pin is also driven out as a gate-enable for the timer that pin controls. All pins are plain control signals. There is no data stream, so there is no handshake.

Top module: `xint_flag_unit`

## Requirements
- R1: While reset is asserted, and right after it, `irq_o`, `gate_en_o` (with pins at their inactive level) and `ctl_rdata_o` are all zero.
- R2: `gate_en_o[i]` equals `pin_i[i]` XNOR `pol_high_i[i]`. It follows a pin change after exactly two rising clock edges.
- R3: In edge mode (type bit = 1) an inactive-to-active transition sets `irq_o[i]` at the third rising edge after the pin change. The flag then holds when the pin returns to inactive.
- R4: In edge mode, `ack_i[i]` high at a rising edge clears `irq_o[i]` at that edge.
- R5: In edge mode, a control write loads the flag bit: writing 0 clears the flag and writing 1 sets it.
- R6: In level mode (type bit = 0), `irq_o[i]` equals `gate_en_o[i]` one cycle earlier. Acknowledges and flag writes do not change it.
- R7: A new active edge in the same cycle as `ack_i[i]` leaves the flag set.
- R8: With `pol_high_i[i]` = 0 the input is active low. A high-to-low pin transition sets the edge-mode flag, and a low-to-high transition does not.
- R9: Control nibble layout: bit 0 is input 0's type, bit 1 is input 0's flag, bit 2 is input 1's type, bit 3 is input 1's flag. A write at a rising edge is read back from the next cycle. The two inputs act independently.
- R10: A new active edge in the same cycle as a control write that clears the flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_IN | Asynchronous request pins |
| pol_high_i | input | NUM_IN | Active level per pin: 1 = high, 0 = low |
| ctl_wr_i | input | 1 | Write strobe for the control nibble |
| ctl_wdata_i | input | 2*NUM_IN | Control write data |
| ack_i | input | NUM_IN | Interrupt acknowledge strobes, one per input |
| ctl_rdata_o | output | 2*NUM_IN | Control nibble readback (types and flags) |
| irq_o | output | NUM_IN | Interrupt request flags |
| gate_en_o | output | NUM_IN | Polarity-adjusted synchronized pin level for timer gating |

## Verification
In edge mode, a fresh active edge can reach the flag in the same cycle that clears it, whether the clear comes from an acknowledge strobe or a software write of zero. The bench provokes this by raising the pin exactly two clock edges before the cycle in which it drives the acknowledge or the clearing write, so that the edge is detected at the same rising edge as the clear. It then requires the flag to be 1 after that edge and still 1 one cycle later, and requires the readback nibble to show the flag set.

// File: rtl/xint_pkg.sv
package xint_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  localparam int CTL_BITS_PER_IN = 2;

  function automatic int type_pos(input int idx);
    return CTL_BITS_PER_IN * idx;
  endfunction

  function automatic int flag_pos(input int idx);
    return CTL_BITS_PER_IN * idx + 1;
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xint_level_edge.sv
module xint_level_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl,
  input  logic pol_high,
  output logic active,
  output logic edge_hit
);
  logic prev_active;

  assign active = ~(sync_lvl ^ pol_high);

  // Seeded to 1 so a pin already active when reset drops is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_active <= 1'b1;
    else        prev_active <= active;
  end

  assign edge_hit = active & ~prev_active;
endmodule

// File: rtl/xint_flag_cell.sv
module xint_flag_cell
  import xint_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e trig,
  input  logic  active,
  input  logic  edge_hit,
  input  logic  ack,
  input  logic  wr_en,
  input  logic  wr_val,
  output logic  flag_q
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = flag_q;
    if (trig == TRIG_LEVEL) begin
      flag_nxt = active;
    end else if (edge_hit) begin
      flag_nxt = 1'b1;            // new edge beats any clear
    end else if (ack) begin
      flag_nxt = 1'b0;
    end else if (wr_en) begin
      flag_nxt = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end
endmodule

// File: rtl/xint_flag_unit.sv
module xint_flag_unit
  import xint_pkg::*;
#(
  parameter int NUM_IN      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CTL_W      = CTL_BITS_PER_IN * NUM_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pin_i,
  input  logic [NUM_IN-1:0] pol_high_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic [NUM_IN-1:0] ack_i,
  output logic [CTL_W-1:0]  ctl_rdata_o,
  output logic [NUM_IN-1:0] irq_o,
  output logic [NUM_IN-1:0] gate_en_o
);
  logic [NUM_IN-1:0] type_q;
  logic [NUM_IN-1:0] sync_lvl;
  logic [NUM_IN-1:0] edge_hit;

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
      localparam int TPOS = type_pos(g);
      localparam int FPOS = flag_pos(g);

      xint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i[g]),
        .q     (sync_lvl[g])
      );

      xint_level_edge u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl[g]),
        .pol_high (pol_high_i[g]),
        .active   (gate_en_o[g]),
        .edge_hit (edge_hit[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        type_q[g] <= 1'b0;
        else if (ctl_wr_i) type_q[g] <= ctl_wdata_i[TPOS];
      end

      xint_flag_cell u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_e'(type_q[g])),
        .active   (gate_en_o[g]),
        .edge_hit (edge_hit[g]),
        .ack      (ack_i[g]),
        .wr_en    (ctl_wr_i),
        .wr_val   (ctl_wdata_i[FPOS]),
        .flag_q   (irq_o[g])
      );

      assign ctl_rdata_o[TPOS] = type_q[g];
      assign ctl_rdata_o[FPOS] = irq_o[g];
    end
  endgenerate
endmodule

// File: rtl/xint_flag_unit_chk.sv
module xint_flag_unit_chk #(
  parameter int NUM_IN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] ack_i,
  input logic              ctl_wr_i,
  input logic [NUM_IN-1:0] type_q,
  input logic [NUM_IN-1:0] edge_hit,
  input logic [NUM_IN-1:0] gate_en_o,
  input logic [NUM_IN-1:0] irq_o
);
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (irq_o == '0));

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
      p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q[i] && edge_hit[i]) |=> irq_o[i]);

      p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q[i] && !edge_hit[i] && !ack_i[i] && !ctl_wr_i) |=> (irq_o[i] == $past(irq_o[i])));

      p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q[i] && ack_i[i] && !edge_hit[i]) |=> !irq_o[i]);

      p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !type_q[i] |=> (irq_o[i] == $past(gate_en_o[i])));

      p_ack_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q[i] && edge_hit[i] && ack_i[i]) |=> irq_o[i]);
    end
  endgenerate
endmodule

bind xint_flag_unit xint_flag_unit_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_i     (ack_i),
  .ctl_wr_i  (ctl_wr_i),
  .type_q    (type_q),
  .edge_hit  (edge_hit),
  .gate_en_o (gate_en_o),
  .irq_o     (irq_o)
);

// File: tb/xint_flag_unit_bench.sv
module xint_flag_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin, pol, ack;
  logic       ctl_wr;
  logic [3:0] wdata;
  logic [3:0] rdata;
  logic [1:0] irq, gate;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  xint_flag_unit u_xint_flag_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pol_high_i(pol),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(wdata), .ack_i(ack),
    .ctl_rdata_o(rdata), .irq_o(irq), .gate_en_o(gate)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_wr = 1'b1; wdata = v; step(); ctl_wr = 1'b0;
  endtask

  task automatic pulse_ack(input int idx);
    ack[idx] = 1'b1; step(); ack = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic t_reset();
    chk("R1", "ctl", 8'(rdata), 8'h0);
    chk("R1", "irq", 8'(irq), 8'h0);
    chk("R1", "gate", 8'(gate), 8'h0);
  endtask

  task automatic t_gate();
    pin[0] = 1'b1; step(1);
    chk("R2", "gate0 after 1 edge", 8'(gate[0]), 8'h0);
    step(1);
    chk("R2", "gate0 after 2 edges", 8'(gate[0]), 8'h1);
    pin[0] = 1'b0; step(2);
    chk("R2", "gate0 low", 8'(gate[0]), 8'h0);
    step(2);
  endtask

  task automatic t_edge();
    wr_ctl(4'b0001);
    chk("R9", "type0 readback", 8'(rdata), 8'h1);
    pin[0] = 1'b1; step(2);
    chk("R3", "irq0 not yet", 8'(irq[0]), 8'h0);
    step(1);
    chk("R3", "irq0 set", 8'(irq[0]), 8'h1);
    pin[0] = 1'b0; step(4);
    chk("R3", "irq0 held", 8'(irq[0]), 8'h1);
  endtask

  task automatic t_ack();
    pulse_ack(0);
    chk("R4", "irq0 cleared", 8'(irq[0]), 8'h0);
    step(2);
    chk("R4", "irq0 stays clear", 8'(irq[0]), 8'h0);
  endtask

  task automatic t_sw();
    wr_ctl(4'b0011);
    chk("R5", "sw set", 8'(irq[0]), 8'h1);
    chk("R9", "flag0 at bit1", 8'(rdata), 8'h3);
    wr_ctl(4'b0001);
    chk("R5", "sw clear", 8'(irq[0]), 8'h0);
  endtask

  task automatic t_collide_ack();
    wr_ctl(4'b0011);
    pin[0] = 1'b1; step(2);
    ack[0] = 1'b1; step(); ack = '0;
    chk("R7", "edge beats ack", 8'(irq[0]), 8'h1);
    step();
    chk("R7", "still set", 8'(irq[0]), 8'h1);
    pin[0] = 1'b0; step(3);
    pulse_ack(0);
  endtask

  task automatic t_collide_wr();
    wr_ctl(4'b0011);
    pin[0] = 1'b1; step(2);
    wr_ctl(4'b0001);
    chk("R10", "edge beats sw clear", 8'(irq[0]), 8'h1);
    chk("R10", "readback", 8'(rdata), 8'h3);
    pin[0] = 1'b0; step(3);
    wr_ctl(4'b0001);
  endtask

  task automatic t_level();
    wr_ctl(4'b0000);
    pin[0] = 1'b1; step(3);
    chk("R6", "level high", 8'(irq[0]), 8'h1);
    pulse_ack(0);
    chk("R6", "ack no effect", 8'(irq[0]), 8'h1);
    wr_ctl(4'b0000);
    chk("R6", "write no effect", 8'(irq[0]), 8'h1);
    pin[0] = 1'b0; step(2);
    chk("R6", "one-cycle lag", 8'(irq[0]), 8'h1);
    step(1);
    chk("R6", "level low", 8'(irq[0]), 8'h0);
  endtask

  task automatic t_polarity();
    wr_ctl(4'b0001);
    pin[0] = 1'b1; pol[0] = 1'b0; step(4);
    chk("R8", "high is inactive", 8'(gate[0]), 8'h0);
    pulse_ack(0);
    pin[0] = 1'b0; step(2);
    chk("R8", "low is active", 8'(gate[0]), 8'h1);
    step(1);
    chk("R8", "falling edge sets", 8'(irq[0]), 8'h1);
    pulse_ack(0);
    pin[0] = 1'b1; step(4);
    chk("R8", "rising edge ignored", 8'(irq[0]), 8'h0);
    pin[0] = 1'b0; pol[0] = 1'b1; step(4);
    pulse_ack(0);
  endtask

  task automatic t_indep();
    wr_ctl(4'b0101);
    chk("R9", "both types", 8'(rdata), 8'h5);
    pin[1] = 1'b1; step(3);
    chk("R9", "only irq1", 8'(irq), 8'h2);
    chk("R9", "flag1 at bit3", 8'(rdata), 8'hD);
    pin[1] = 1'b0;
    pulse_ack(1);
    chk("R4", "ack1 clears irq1", 8'(irq), 8'h0);
    chk("R9", "readback after ack1", 8'(rdata), 8'h5);
  endtask

  initial begin
    rst_n = 1'b0; pin = '0; pol = 2'b11; ack = '0; ctl_wr = 1'b0; wdata = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_gate();
    t_edge();
    t_ack();
    t_sw();
    t_collide_ack();
    t_collide_wr();
    t_level();
    t_polarity();
    t_indep();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule